// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical timing a parallel display panel needs. Its inputs are run-time settings: the active width and height, and the front porch, sync length and back porch on each axis. From these it drives a horizontal sync, a vertical sync, a data-enable strobe and the x/y coordinate of the pixel on the wire. Each line steps through four phases in pixel clocks. Each frame steps through the same four phases, counted in lines.

Each of the three strobes has its own polarity bit and its own "in use" bit. The launch clock edge is chosen once for the data group (enable and coordinates). It is chosen separately for the sync group, and the sync group follows the data edge unless its own edge control is switched on. A double-scan option sends every active line twice. All settings are captured together at the first pixel of a frame, so a write in the middle of a frame never produces a broken line.

Top module: `rtg_top`

## Requirements
- R1: Each line runs for cfg_h_act active clocks, then cfg_h_fp front-porch clocks, then cfg_h_sync clocks with hsync asserted, then cfg_h_bp back-porch clocks, and then starts again. The line length is the sum of the four fields, and every field is at least 1.
- R2: Each frame runs cfg_v_act active lines, then cfg_v_fp lines, then cfg_v_sync lines with vsync asserted, then cfg_v_bp lines. Without double scan, a line counts as one full horizontal period.
- R3: de is asserted only when the pixel is inside both the horizontal and the vertical active phases.
- R4: While de is asserted, px_x gives the pixel index within the line (0 at the first active pixel) and px_y gives the active line index (0 at the first active line). At all other times both are 0.
- R5: A polarity bit (cfg_hs_pol, cfg_vs_pol, cfg_de_pol) of 1 makes its output high when asserted and low otherwise. A polarity bit of 0 inverts that output.
- R6: When an output's in-use bit (cfg_hs_en, cfg_vs_en, cfg_de_en) is 0, that output stays at its inactive level, which is the inverse of its polarity bit.
- R7: With cfg_data_rise = 1, de, px_x and px_y change at the rising clock edge one clock after the counter state they show. With 0, they change at the following falling edge, half a clock later.
- R8: With cfg_sync_own = 1, cfg_sync_rise picks the launch edge for hsync and vsync, with the same meaning as R7. With cfg_sync_own = 0, the syncs use cfg_data_rise.
- R9: With cfg_dscan = 1, each of the cfg_v_act active lines is output in two consecutive horizontal periods with the same px_y. The vertical porches and sync are not doubled.
- R10: All cfg inputs are captured only at the transition to the first pixel of a new frame, and while rst is high. A change at any other time has no effect until the next frame starts.
- R11: While rst is high at a rising edge, the counters return to the first active pixel of line 0 and every output goes to its inactive level. The first output after rst falls shows pixel (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_h_act | input | HW | Active pixels per line |
| cfg_h_fp | input | HW | Horizontal front porch in clocks |
| cfg_h_sync | input | HW | Horizontal sync length in clocks |
| cfg_h_bp | input | HW | Horizontal back porch in clocks |
| cfg_v_act | input | VW | Active lines per frame |
| cfg_v_fp | input | VW | Vertical front porch in lines |
| cfg_v_sync | input | VW | Vertical sync length in lines |
| cfg_v_bp | input | VW | Vertical back porch in lines |
| cfg_hs_pol | input | 1 | hsync asserted level |
| cfg_vs_pol | input | 1 | vsync asserted level |
| cfg_de_pol | input | 1 | de asserted level |
| cfg_hs_en | input | 1 | hsync in use |
| cfg_vs_en | input | 1 | vsync in use |
| cfg_de_en | input | 1 | de in use |
| cfg_data_rise | input | 1 | Data group launch edge: 1 rising, 0 falling |
| cfg_sync_own | input | 1 | Sync group uses its own edge control |
| cfg_sync_rise | input | 1 | Sync group launch edge when cfg_sync_own is 1 |
| cfg_dscan | input | 1 | Double-scan enable |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| px_x | output | HW | Pixel x coordinate |
| px_y | output | VW | Line y coordinate |

## Verification
Each output shows the counter state from before the most recent rising edge. A rising-launched output changes at that edge, and a falling-launched output changes half a clock later. The bench therefore samples twice per clock. A quarter clock after the rising edge, it expects the new value from rising-launched outputs and the previous clock's value from falling-launched ones. A quarter clock after the falling edge, it expects the new value on every output. A reference raster model steps once per clock and loads its settings only when it wraps to a new frame. Settings changed in the middle of a frame are therefore expected to take effect exactly at the next frame's first pixel.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

    typedef enum logic [1:0] {
        PH_ACT  = 2'd0,
        PH_FP   = 2'd1,
        PH_SYNC = 2'd2,
        PH_BP   = 2'd3
    } phase_t;

    typedef struct packed {
        logic hs_pol;
        logic vs_pol;
        logic de_pol;
        logic hs_en;
        logic vs_en;
        logic de_en;
        logic data_rise;
        logic sync_own;
        logic sync_rise;
        logic dscan;
    } ctl_t;

    function automatic logic out_level(input logic en, input logic on, input logic pol);
        return (en && on) ? pol : ~pol;
    endfunction

endpackage

// File: rtl/rtg_axis.sv
module rtg_axis
    import rtg_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic [W-1:0] len_act,
    input  logic [W-1:0] len_fp,
    input  logic [W-1:0] len_sync,
    input  logic [W-1:0] len_bp,
    output phase_t       phase,
    output logic [W-1:0] cnt,
    output logic         wrap
);

    typedef struct packed {
        phase_t       ph;
        logic [W-1:0] cnt;
    } st_t;

    st_t          st_d, st_q;
    logic [W-1:0] last;
    logic         at_end;

    always_comb begin
        case (st_q.ph)
            PH_ACT:  last = len_act - W'(1);
            PH_FP:   last = len_fp - W'(1);
            PH_SYNC: last = len_sync - W'(1);
            default: last = len_bp - W'(1);
        endcase
        at_end = (st_q.cnt == last);
        wrap   = step && at_end && (st_q.ph == PH_BP);
        st_d   = st_q;
        if (rst) begin
            st_d.ph  = PH_ACT;
            st_d.cnt = '0;
        end else if (step) begin
            if (at_end) begin
                st_d.cnt = '0;
                st_d.ph  = phase_t'(st_q.ph + 2'd1);
            end else begin
                st_d.cnt = st_q.cnt + W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign phase = st_q.ph;
    assign cnt   = st_q.cnt;

endmodule

// File: rtl/rtg_launch.sv
module rtg_launch #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rise_sel,
    input  logic [W-1:0] d_pos,
    output logic [W-1:0] q
);

    logic [W-1:0] neg_q;

    always_ff @(negedge clk) begin
        neg_q <= d_pos;
    end

    assign q = rise_sel ? d_pos : neg_q;

endmodule

// File: rtl/rtg_top.sv
module rtg_top
    import rtg_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [HW-1:0] cfg_h_act,
    input  logic [HW-1:0] cfg_h_fp,
    input  logic [HW-1:0] cfg_h_sync,
    input  logic [HW-1:0] cfg_h_bp,
    input  logic [VW-1:0] cfg_v_act,
    input  logic [VW-1:0] cfg_v_fp,
    input  logic [VW-1:0] cfg_v_sync,
    input  logic [VW-1:0] cfg_v_bp,
    input  logic          cfg_hs_pol,
    input  logic          cfg_vs_pol,
    input  logic          cfg_de_pol,
    input  logic          cfg_hs_en,
    input  logic          cfg_vs_en,
    input  logic          cfg_de_en,
    input  logic          cfg_data_rise,
    input  logic          cfg_sync_own,
    input  logic          cfg_sync_rise,
    input  logic          cfg_dscan,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic [HW-1:0] px_x,
    output logic [VW-1:0] px_y
);

    localparam int DW = 1 + HW + VW;

    typedef struct packed {
        logic [HW-1:0] h_act;
        logic [HW-1:0] h_fp;
        logic [HW-1:0] h_sync;
        logic [HW-1:0] h_bp;
        logic [VW-1:0] v_act;
        logic [VW-1:0] v_fp;
        logic [VW-1:0] v_sync;
        logic [VW-1:0] v_bp;
        ctl_t          ctl;
    } shd_t;

    typedef struct packed {
        shd_t          sh;
        logic          rep;
        logic          hs_lvl;
        logic          vs_lvl;
        logic          de_lvl;
        logic [HW-1:0] x;
        logic [VW-1:0] y;
    } st_t;

    st_t           st_d, st_q;
    shd_t          cfg_in;
    phase_t        h_phase, v_phase;
    logic [HW-1:0] h_cnt;
    logic [VW-1:0] v_cnt;
    logic          h_wrap, v_wrap, v_step;
    logic          de_on, sync_rise;
    logic [DW-1:0] data_pos, data_out;
    logic [1:0]    sync_pos, sync_out;

    always_comb begin
        cfg_in.h_act         = cfg_h_act;
        cfg_in.h_fp          = cfg_h_fp;
        cfg_in.h_sync        = cfg_h_sync;
        cfg_in.h_bp          = cfg_h_bp;
        cfg_in.v_act         = cfg_v_act;
        cfg_in.v_fp          = cfg_v_fp;
        cfg_in.v_sync        = cfg_v_sync;
        cfg_in.v_bp          = cfg_v_bp;
        cfg_in.ctl.hs_pol    = cfg_hs_pol;
        cfg_in.ctl.vs_pol    = cfg_vs_pol;
        cfg_in.ctl.de_pol    = cfg_de_pol;
        cfg_in.ctl.hs_en     = cfg_hs_en;
        cfg_in.ctl.vs_en     = cfg_vs_en;
        cfg_in.ctl.de_en     = cfg_de_en;
        cfg_in.ctl.data_rise = cfg_data_rise;
        cfg_in.ctl.sync_own  = cfg_sync_own;
        cfg_in.ctl.sync_rise = cfg_sync_rise;
        cfg_in.ctl.dscan     = cfg_dscan;
    end

    // A vertical step is held back on the first pass of a doubled line.
    assign v_step = h_wrap &&
                    !(st_q.sh.ctl.dscan && (v_phase == PH_ACT) && !st_q.rep);

    rtg_axis #(.W(HW)) u_h (
        .clk      (clk),
        .rst      (rst),
        .step     (1'b1),
        .len_act  (st_q.sh.h_act),
        .len_fp   (st_q.sh.h_fp),
        .len_sync (st_q.sh.h_sync),
        .len_bp   (st_q.sh.h_bp),
        .phase    (h_phase),
        .cnt      (h_cnt),
        .wrap     (h_wrap)
    );

    rtg_axis #(.W(VW)) u_v (
        .clk      (clk),
        .rst      (rst),
        .step     (v_step),
        .len_act  (st_q.sh.v_act),
        .len_fp   (st_q.sh.v_fp),
        .len_sync (st_q.sh.v_sync),
        .len_bp   (st_q.sh.v_bp),
        .phase    (v_phase),
        .cnt      (v_cnt),
        .wrap     (v_wrap)
    );

    always_comb begin
        de_on = (h_phase == PH_ACT) && (v_phase == PH_ACT);
        st_d  = st_q;
        if (rst) begin
            st_d.sh     = cfg_in;
            st_d.rep    = 1'b0;
            st_d.hs_lvl = ~cfg_in.ctl.hs_pol;
            st_d.vs_lvl = ~cfg_in.ctl.vs_pol;
            st_d.de_lvl = ~cfg_in.ctl.de_pol;
            st_d.x      = '0;
            st_d.y      = '0;
        end else begin
            st_d.hs_lvl = out_level(st_q.sh.ctl.hs_en, h_phase == PH_SYNC, st_q.sh.ctl.hs_pol);
            st_d.vs_lvl = out_level(st_q.sh.ctl.vs_en, v_phase == PH_SYNC, st_q.sh.ctl.vs_pol);
            st_d.de_lvl = out_level(st_q.sh.ctl.de_en, de_on, st_q.sh.ctl.de_pol);
            st_d.x      = de_on ? h_cnt : '0;
            st_d.y      = de_on ? v_cnt : '0;
            if (h_wrap && st_q.sh.ctl.dscan && (v_phase == PH_ACT)) begin
                st_d.rep = ~st_q.rep;
            end
            if (v_wrap) begin
                st_d.sh  = cfg_in;
                st_d.rep = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sync_rise = st_q.sh.ctl.sync_own ? st_q.sh.ctl.sync_rise
                                            : st_q.sh.ctl.data_rise;
    assign data_pos  = {st_q.de_lvl, st_q.x, st_q.y};
    assign sync_pos  = {st_q.hs_lvl, st_q.vs_lvl};

    rtg_launch #(.W(DW)) u_data_launch (
        .clk      (clk),
        .rise_sel (st_q.sh.ctl.data_rise),
        .d_pos    (data_pos),
        .q        (data_out)
    );

    rtg_launch #(.W(2)) u_sync_launch (
        .clk      (clk),
        .rise_sel (sync_rise),
        .d_pos    (sync_pos),
        .q        (sync_out)
    );

    assign de    = data_out[DW-1];
    assign px_x  = data_out[VW +: HW];
    assign px_y  = data_out[VW-1:0];
    assign hsync = sync_out[1];
    assign vsync = sync_out[0];

endmodule

// File: rtl/rtg_check.sv
module rtg_check
    import rtg_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input logic          clk,
    input logic          rst,
    input phase_t        h_phase,
    input phase_t        v_phase,
    input logic [VW-1:0] v_cnt,
    input logic          h_wrap,
    input logic          rep,
    input logic          dscan,
    input logic          hs_en,
    input logic          hs_pol,
    input logic          stage_hs,
    input logic [HW-1:0] stage_x
);

    // R1: the line phase only ever moves forward by one step
    a_r1_h_phase_order: assert property (@(posedge clk) disable iff (rst)
        (h_phase != $past(h_phase)) |-> (h_phase == phase_t'($past(h_phase) + 2'd1)));

    // R2: the frame phase only ever moves forward by one step
    a_r2_v_phase_order: assert property (@(posedge clk) disable iff (rst)
        (v_phase != $past(v_phase)) |-> (v_phase == phase_t'($past(v_phase) + 2'd1)));

    // R4: a nonzero x coordinate only comes from a horizontally active pixel
    a_r4_x_in_active: assert property (@(posedge clk) disable iff (rst)
        (stage_x != '0) |-> $past(h_phase == PH_ACT));

    // R6: an unused hsync sits at the inverse of its polarity bit
    a_r6_unused_hs: assert property (@(posedge clk) disable iff (rst)
        $past(!hs_en) |-> (stage_hs == $past(!hs_pol)));

    // R9: the first pass of a doubled active line keeps the line counter
    a_r9_dscan_hold: assert property (@(posedge clk) disable iff (rst)
        $past(dscan && (v_phase == PH_ACT) && !rep && h_wrap)
        |-> ((v_phase == PH_ACT) && (v_cnt == $past(v_cnt))));

endmodule

bind rtg_top rtg_check #(.HW(HW), .VW(VW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .h_phase  (h_phase),
    .v_phase  (v_phase),
    .v_cnt    (v_cnt),
    .h_wrap   (h_wrap),
    .rep      (st_q.rep),
    .dscan    (st_q.sh.ctl.dscan),
    .hs_en    (st_q.sh.ctl.hs_en),
    .hs_pol   (st_q.sh.ctl.hs_pol),
    .stage_hs (st_q.hs_lvl),
    .stage_x  (st_q.x)
);

// File: tb/sim_rtg_top.sv
`timescale 1ns/1ps
module sim_rtg_top;

    localparam int HW = 12;
    localparam int VW = 11;

    typedef struct {
        int ha, hf, hs, hb, va, vf, vs, vb;
        bit hpol, vpol, dpol, hen, ven, den, drise, sown, srise, dscan;
    } bcfg_t;

    typedef struct {
        bit de, hs, vs;
        int x, y;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    bcfg_t cur, shd;
    int    hp, vl;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string ptag;

    logic          hsync, vsync, de;
    logic [HW-1:0] px_x;
    logic [VW-1:0] px_y;

    rtg_top #(.HW(HW), .VW(VW)) u0 (
        .clk           (clk),
        .rst           (rst),
        .cfg_h_act     (HW'(cur.ha)),
        .cfg_h_fp      (HW'(cur.hf)),
        .cfg_h_sync    (HW'(cur.hs)),
        .cfg_h_bp      (HW'(cur.hb)),
        .cfg_v_act     (VW'(cur.va)),
        .cfg_v_fp      (VW'(cur.vf)),
        .cfg_v_sync    (VW'(cur.vs)),
        .cfg_v_bp      (VW'(cur.vb)),
        .cfg_hs_pol    (cur.hpol),
        .cfg_vs_pol    (cur.vpol),
        .cfg_de_pol    (cur.dpol),
        .cfg_hs_en     (cur.hen),
        .cfg_vs_en     (cur.ven),
        .cfg_de_en     (cur.den),
        .cfg_data_rise (cur.drise),
        .cfg_sync_own  (cur.sown),
        .cfg_sync_rise (cur.srise),
        .cfg_dscan     (cur.dscan),
        .hsync         (hsync),
        .vsync         (vsync),
        .de            (de),
        .px_x          (px_x),
        .px_y          (px_y)
    );

    function automatic exp_t idle_of(bcfg_t c);
        exp_t e;
        e.de = !c.dpol; e.hs = !c.hpol; e.vs = !c.vpol; e.x = 0; e.y = 0;
        return e;
    endfunction

    function automatic exp_t calc(int h, int v, bcfg_t c);
        exp_t e;
        int   span;
        bit   hon, von, hsy, vsy;
        span = c.dscan ? 2 * c.va : c.va;
        hon  = h < c.ha;
        hsy  = (h >= c.ha + c.hf) && (h < c.ha + c.hf + c.hs);
        von  = v < span;
        vsy  = (v >= span + c.vf) && (v < span + c.vf + c.vs);
        e.de = (c.den && hon && von) ? c.dpol : !c.dpol;
        e.hs = (c.hen && hsy) ? c.hpol : !c.hpol;
        e.vs = (c.ven && vsy) ? c.vpol : !c.vpol;
        e.x  = (hon && von) ? h : 0;
        e.y  = (hon && von) ? (c.dscan ? v / 2 : v) : 0;
        return e;
    endfunction

    function automatic bcfg_t rand_cfg();
        bcfg_t c;
        c.ha = 1 + int'($urandom_range(5)); c.hf = 1 + int'($urandom_range(2));
        c.hs = 1 + int'($urandom_range(2)); c.hb = 1 + int'($urandom_range(2));
        c.va = 1 + int'($urandom_range(3)); c.vf = 1 + int'($urandom_range(1));
        c.vs = 1 + int'($urandom_range(1)); c.vb = 1 + int'($urandom_range(1));
        c.hpol = 1'($urandom); c.vpol = 1'($urandom); c.dpol = 1'($urandom);
        c.hen = ($urandom_range(3) != 0); c.ven = ($urandom_range(3) != 0);
        c.den = ($urandom_range(3) != 0);
        c.drise = 1'($urandom); c.sown = 1'($urandom); c.srise = 1'($urandom);
        c.dscan = 1'($urandom);
        return c;
    endfunction

    task automatic chk(string tag, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s/%s actual=%0d expected=%0d at %0t", tag, ptag, act, expv, $time);
        end
    endtask

    exp_t prev;

    // One clock: mid-high sample for launch edges, post-fall sample for values.
    task automatic run_cycles(int n);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            bit   dr, sr;
            @(posedge clk);
            #1.25;
            e = calc(hp, vl, shd);
            hp++;
            if (hp == shd.ha + shd.hf + shd.hs + shd.hb) begin
                hp = 0;
                vl++;
                if (vl == (shd.dscan ? 2 * shd.va : shd.va) + shd.vf + shd.vs + shd.vb) begin
                    vl  = 0;
                    shd = cur;
                end
            end
            dr = shd.drise;
            sr = shd.sown ? shd.srise : shd.drise;
            chk("R7 de edge", int'(de), int'(dr ? e.de : prev.de));
            chk("R7 x edge", int'(px_x), dr ? e.x : prev.x);
            chk("R7 y edge", int'(px_y), dr ? e.y : prev.y);
            chk("R8 hsync edge", int'(hsync), int'(sr ? e.hs : prev.hs));
            chk("R8 vsync edge", int'(vsync), int'(sr ? e.vs : prev.vs));
            #2.5;
            chk("R3 de", int'(de), int'(e.de));
            chk("R1 hsync", int'(hsync), int'(e.hs));
            chk("R2 vsync", int'(vsync), int'(e.vs));
            chk("R4 x", int'(px_x), e.x);
            chk("R4 y", int'(px_y), e.y);
            prev = e;
        end
    endtask

    initial begin
        void'($urandom(32'd7321));
        cur = '{ha:4, hf:1, hs:2, hb:1, va:3, vf:1, vs:1, vb:2,
                hpol:0, vpol:1, dpol:1, hen:1, ven:1, den:1,
                drise:1, sown:0, srise:0, dscan:0};
        repeat (4) @(posedge clk);
        #3.75;
        ptag = "R11";
        chk("R11 reset hsync", int'(hsync), 1);
        chk("R11 reset vsync", int'(vsync), 0);
        chk("R11 reset de", int'(de), 0);
        chk("R11 reset x", int'(px_x), 0);
        chk("R11 reset y", int'(px_y), 0);
        rst  = 1'b0;
        shd  = cur;
        hp   = 0;
        vl   = 0;
        prev = idle_of(cur);
        run_cycles(130);

        // R5: inverted polarities, falling data edge, taken at next frame
        ptag = "R5";
        cur.hpol = 1; cur.vpol = 0; cur.dpol = 0; cur.drise = 0;
        run_cycles(150);

        // R10: several changes in the middle of a frame
        ptag = "R10";
        run_cycles(13);
        cur.ha = 2; cur.hb = 3;
        run_cycles(5);
        cur.va = 2; cur.dpol = 1;
        run_cycles(160);

        // R9 and R6: double scan, own sync edge, unused outputs
        ptag = "R9";
        cur.dscan = 1; cur.sown = 1; cur.srise = 1; cur.drise = 0;
        run_cycles(200);
        ptag = "R6";
        cur.hen = 0; cur.den = 0; cur.sown = 1; cur.srise = 0; cur.drise = 1;
        run_cycles(200);
        cur.hen = 1; cur.den = 1; cur.ven = 0;
        run_cycles(200);

        // R1: random settings changed at random points
        ptag = "R1 random";
        for (int k = 0; k < 120; k++) begin
            cur = rand_cfg();
            run_cycles(20 + int'($urandom_range(60)));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule